// File: doc/BRIEF.md
# Commanded Serial Transmit Channel

This block is the transmit half of an asynchronous serial port. A host loads bytes into a 256-entry queue. The channel turns each byte into a serial frame on `txd`: a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit, and one or two high stop bits. Bit timing comes from one of two clock enables. In oversampled mode, each bit lasts 16 pulses of `tick16`. In direct mode, used when an external bit clock has been chosen, each bit lasts one pulse of `ext_tick`.

The host controls the channel with single-cycle command pulses: enable, disable, reset, start break and stop break. Disable is graceful: every queued character is still sent, but new writes are refused at once. Reset is abrupt: the line goes high, the queue is emptied and both flags clear. A break holds the line low until the host ends it. The line then rests high for one bit time before sending resumes.

Two flags report progress. `tx_ready` means the channel will accept a byte. `tx_idle` means there is nothing left to send.

Top module: `sertx_channel`

## Requirements
- R1: `tx_ready` is high exactly when the channel is enabled and the queue holds fewer than 256 bytes. It is low whenever the queue is full.
- R2: `tx_idle` is high exactly when the channel is enabled, the queue is empty and the serializer is neither framing, breaking nor in its post-break guard time. `tx_idle` is never high while `tx_ready` is low.
- R3: The cycle after an enable command, with an empty queue, both flags are high. An accepted write makes `tx_idle` low the cycle after it.
- R4: A write is dropped when the channel is disabled or the queue is full. A dropped byte is never sent.
- R5: After a disable command, both flags are low from the next cycle on. Every byte already queued is still sent in full, including its stop bits.
- R6: A reset, either `rst` or a `cmd_reset` pulse, makes `txd` high and both flags low from the next cycle on. It drops the channel to disabled, abandons the current frame and empties the queue.
- R7: A start-break command forces `txd` low from the next cycle on and keeps it low until a stop-break command or a reset. A frame in flight is abandoned. Queued bytes are kept.
- R8: After stop-break, `txd` stays high for one full bit time before the next start bit can begin.
- R9: Frame layout. The frame starts with a start bit of 0. Then come the data bits, least significant first; `char_len` gives their count as 0→5, 1→6, 2→7, 3→8. Then comes the parity bit, if enabled. Last come the stop bits at 1: one stop bit, or two when `two_stop` is 1.
- R10: `par_mode` codes: 0 gives no parity bit. 1 gives even parity (the data bits plus the parity bit hold an even number of ones). 2 gives odd parity. 3 gives a parity bit equal to `par_force_val`.
- R11: With `ext_1x_sel` at 0, a bit lasts 16 `tick16` pulses. With `ext_1x_sel` at 1, a bit lasts one `ext_tick` pulse. When the serializer is idle and a byte is waiting, the start bit begins at the first such pulse. In oversampled mode this is within 1/16 of a bit time.
- R12: When a frame's last stop bit ends and another byte is waiting, that byte's start bit follows with no gap.
- R13: Command priority within one cycle: reset over everything else, disable over enable, and start-break over stop-break.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Oversampled bit-rate enable, 16 per bit |
| ext_1x_sel | input | 1 | 1 selects the direct external bit clock enable |
| ext_tick | input | 1 | External bit clock enable, one per bit |
| cmd_enable | input | 1 | Enable command pulse |
| cmd_disable | input | 1 | Graceful disable command pulse |
| cmd_reset | input | 1 | Channel reset command pulse |
| cmd_brk_on | input | 1 | Start-break command pulse |
| cmd_brk_off | input | 1 | Stop-break command pulse |
| wr_en | input | 1 | Queue write strobe |
| wr_data | input | 8 | Byte to queue |
| char_len | input | 2 | Data bit count code |
| par_mode | input | 2 | Parity mode code |
| par_force_val | input | 1 | Parity bit value in forced mode |
| two_stop | input | 1 | 1 selects two stop bits |
| txd | output | 1 | Serial line, idle high |
| tx_ready | output | 1 | Channel accepts a byte |
| tx_idle | output | 1 | Channel enabled with nothing left to send |

## Verification
A wrong enable bit or queue count shows on `tx_ready` or `tx_idle` on the very next cycle, because both flags are decoded from state alone. A dropped, duplicated or misordered queue entry, or a wrong bit counter, shows on `txd` within one bit time of the frame that carries it. A serializer stuck in break or guard keeps `tx_idle` low and holds the line level, which shows at the first bit boundary where the reference expects a change. Each cycle, the bench compares all three outputs with a behavioural model, so a divergence is caught at the cycle where it first appears.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int FRAME_W = 12;
    localparam int FCNT_W  = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_BRK   = 2'd2,
        ST_GUARD = 2'd3
    } tx_state_e;

    typedef struct packed {
        logic [1:0] len_code;
        logic [1:0] par_mode;
        logic       par_val;
        logic       two_stop;
    } frame_cfg_t;

    function automatic logic calc_parity(input logic [7:0] d, input frame_cfg_t c);
        logic [7:0] mask;
        logic [7:0] md;
        mask = 8'hFF >> (2'd3 - c.len_code);
        md   = d & mask;
        case (c.par_mode)
            2'd1:    return ^md;
            2'd2:    return ~^md;
            default: return c.par_val;
        endcase
    endfunction

    function automatic logic [FRAME_W-1:0] build_frame(input logic [7:0] d, input frame_cfg_t c);
        logic [7:0]         mask;
        logic [FRAME_W-1:0] tail;
        logic [FCNT_W-1:0]  sh;
        mask = 8'hFF >> (2'd3 - c.len_code);
        sh   = FCNT_W'(6) + FCNT_W'(c.len_code);
        if (c.par_mode != 2'd0)
            tail = {{(FRAME_W-1){1'b1}}, calc_parity(d, c)};
        else
            tail = {FRAME_W{1'b1}};
        return (tail << sh) | {3'b000, d & mask, 1'b0};
    endfunction

    function automatic logic [FCNT_W-1:0] frame_bits(input frame_cfg_t c);
        return FCNT_W'(7) + FCNT_W'(c.len_code)
             + FCNT_W'(c.par_mode != 2'd0) + FCNT_W'(c.two_stop);
    endfunction

endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
    parameter int DEPTH = 256,
    parameter int W     = 8
) (
    input  logic                       clk,
    input  logic                       flush,
    input  logic                       wr,
    input  logic [W-1:0]               wdata,
    input  logic                       rd,
    output logic [W-1:0]               rdata,
    output logic [$clog2(DEPTH):0]     count
);
    localparam int AW    = $clog2(DEPTH);
    localparam int CNT_W = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;

    assign rdata = mem[rptr];

    always_ff @(posedge clk) begin
        if (wr) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr) wptr <= wptr + AW'(1);
            if (rd) rptr <= rptr + AW'(1);
            count <= count + CNT_W'(wr) - CNT_W'(rd);
        end
    end
endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl #(
    parameter int DEPTH = 256,
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_reset,
    input  logic             cmd_enable,
    input  logic             cmd_disable,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] count,
    input  logic             ser_quiet,
    output logic             flush,
    output logic             accept,
    output logic             tx_ready,
    output logic             tx_idle
);
    logic en_q;
    logic full;

    assign flush    = rst | cmd_reset;
    assign full     = (count == CNT_W'(DEPTH));
    assign accept   = wr_en & en_q & ~full;
    assign tx_ready = en_q & ~full;
    assign tx_idle  = en_q & (count == '0) & ser_quiet;

    always_ff @(posedge clk) begin
        if (flush)            en_q <= 1'b0;
        else if (cmd_disable) en_q <= 1'b0;
        else if (cmd_enable)  en_q <= 1'b1;
    end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic               clk,
    input  logic               clr,
    input  logic               ce,
    input  logic               one_x,
    input  logic               brk_on,
    input  logic               brk_off,
    input  logic               have_data,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic [FCNT_W-1:0]  nbits_in,
    output logic               pop,
    output logic               txd,
    output logic               quiet
);
    localparam int SUB_W = $clog2(OVERSAMPLE);

    tx_state_e          state;
    logic [SUB_W-1:0]   sub;
    logic [FCNT_W-1:0]  left;
    logic [FRAME_W-1:0] shreg;
    logic               sub_last;
    logic               bit_end;

    assign sub_last = one_x | (sub == SUB_W'(OVERSAMPLE - 1));
    assign bit_end  = ce & sub_last;

    always_comb begin
        pop = 1'b0;
        if (!brk_on && have_data) begin
            if (state == ST_IDLE && ce)
                pop = 1'b1;
            else if (state == ST_SHIFT && bit_end && left == FCNT_W'(1))
                pop = 1'b1;
        end
    end

    assign txd   = (state == ST_SHIFT) ? shreg[0] : (state != ST_BRK);
    assign quiet = (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (clr) begin
            state <= ST_IDLE;
            sub   <= '0;
            left  <= '0;
            shreg <= '1;
        end else if (brk_on) begin
            state <= ST_BRK;
            sub   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (pop) begin
                        shreg <= frame_in;
                        left  <= nbits_in;
                        sub   <= '0;
                        state <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (ce) begin
                        if (sub_last) begin
                            sub <= '0;
                            if (left == FCNT_W'(1)) begin
                                if (pop) begin
                                    shreg <= frame_in;
                                    left  <= nbits_in;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                shreg <= {1'b1, shreg[FRAME_W-1:1]};
                                left  <= left - FCNT_W'(1);
                            end
                        end else begin
                            sub <= sub + SUB_W'(1);
                        end
                    end
                end
                ST_BRK: begin
                    if (brk_off) begin
                        state <= ST_GUARD;
                        sub   <= '0;
                    end
                end
                ST_GUARD: begin
                    if (ce) begin
                        if (sub_last) begin
                            sub   <= '0;
                            state <= ST_IDLE;
                        end else begin
                            sub <= sub + SUB_W'(1);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sertx_channel.sv
module sertx_channel
    import sertx_pkg::*;
#(
    parameter int DEPTH      = 256,
    parameter int OVERSAMPLE = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick16,
    input  logic       ext_1x_sel,
    input  logic       ext_tick,
    input  logic       cmd_enable,
    input  logic       cmd_disable,
    input  logic       cmd_reset,
    input  logic       cmd_brk_on,
    input  logic       cmd_brk_off,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic [1:0] char_len,
    input  logic [1:0] par_mode,
    input  logic       par_force_val,
    input  logic       two_stop,
    output logic       txd,
    output logic       tx_ready,
    output logic       tx_idle
);
    localparam int CNT_W = $clog2(DEPTH) + 1;

    frame_cfg_t         cfg;
    logic               flush, accept, pop, ser_quiet, ce;
    logic [7:0]         head;
    logic [CNT_W-1:0]   fifo_cnt;
    logic [FRAME_W-1:0] frame;
    logic [FCNT_W-1:0]  nbits;

    assign cfg   = '{len_code: char_len, par_mode: par_mode,
                     par_val: par_force_val, two_stop: two_stop};
    assign ce    = ext_1x_sel ? ext_tick : tick16;
    assign frame = build_frame(head, cfg);
    assign nbits = frame_bits(cfg);

    sertx_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cmd_reset  (cmd_reset),
        .cmd_enable (cmd_enable),
        .cmd_disable(cmd_disable),
        .wr_en      (wr_en),
        .count      (fifo_cnt),
        .ser_quiet  (ser_quiet),
        .flush      (flush),
        .accept     (accept),
        .tx_ready   (tx_ready),
        .tx_idle    (tx_idle)
    );

    sertx_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
        .clk  (clk),
        .flush(flush),
        .wr   (accept),
        .wdata(wr_data),
        .rd   (pop),
        .rdata(head),
        .count(fifo_cnt)
    );

    sertx_shifter #(.OVERSAMPLE(OVERSAMPLE)) u_ser (
        .clk      (clk),
        .clr      (flush),
        .ce       (ce),
        .one_x    (ext_1x_sel),
        .brk_on   (cmd_brk_on),
        .brk_off  (cmd_brk_off),
        .have_data(fifo_cnt != '0),
        .frame_in (frame),
        .nbits_in (nbits),
        .pop      (pop),
        .txd      (txd),
        .quiet    (ser_quiet)
    );
endmodule

// File: rtl/sertx_checks.sv
module sertx_checks #(
    parameter int DEPTH = 256,
    parameter int CNT_W = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_reset,
    input logic             cmd_brk_on,
    input logic             wr_en,
    input logic             txd,
    input logic             tx_ready,
    input logic             tx_idle,
    input logic [CNT_W-1:0] fifo_cnt
);
    a_r2_idle_needs_ready: assert property (@(posedge clk) disable iff (rst)
        tx_idle |-> tx_ready);

    a_r1_full_blocks_ready: assert property (@(posedge clk) disable iff (rst)
        (fifo_cnt == CNT_W'(DEPTH)) |-> !tx_ready);

    a_r6_reset_clears: assert property (@(posedge clk) disable iff (rst)
        cmd_reset |=> (txd && !tx_ready && !tx_idle && fifo_cnt == '0));

    a_r7_break_low: assert property (@(posedge clk) disable iff (rst)
        (cmd_brk_on && !cmd_reset) |=> !txd);

    a_r4_refused_no_growth: assert property (@(posedge clk) disable iff (rst)
        (!tx_ready && !cmd_reset) |=> (fifo_cnt <= $past(fifo_cnt)));

    a_r3_write_clears_idle: assert property (@(posedge clk) disable iff (rst)
        (wr_en && tx_ready && !cmd_reset) |=> !tx_idle);
endmodule

bind sertx_channel sertx_checks #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_checks (
    .clk       (clk),
    .rst       (rst),
    .cmd_reset (cmd_reset),
    .cmd_brk_on(cmd_brk_on),
    .wr_en     (wr_en),
    .txd       (txd),
    .tx_ready  (tx_ready),
    .tx_idle   (tx_idle),
    .fifo_cnt  (fifo_cnt)
);

// File: tb/sertx_channel_bench.sv
module sertx_channel_bench;
    localparam int DEPTH = 256;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick16 = 1'b0, ext_1x_sel = 1'b0, ext_tick = 1'b0;
    logic cmd_enable = 1'b0, cmd_disable = 1'b0, cmd_reset = 1'b0;
    logic cmd_brk_on = 1'b0, cmd_brk_off = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] char_len = 2'd3, par_mode = 2'd0;
    logic par_force_val = 1'b0, two_stop = 1'b0;
    logic txd, tx_ready, tx_idle;

    int total = 0, bad = 0, cycles = 0;
    bit cmp_on = 1'b0, tick_run = 1'b1;
    int tcnt = 0, ext_div = 3;

    always #10 clk = ~clk;

    sertx_channel u_sertx_channel (
        .clk(clk), .rst(rst), .tick16(tick16), .ext_1x_sel(ext_1x_sel),
        .ext_tick(ext_tick), .cmd_enable(cmd_enable), .cmd_disable(cmd_disable),
        .cmd_reset(cmd_reset), .cmd_brk_on(cmd_brk_on), .cmd_brk_off(cmd_brk_off),
        .wr_en(wr_en), .wr_data(wr_data), .char_len(char_len), .par_mode(par_mode),
        .par_force_val(par_force_val), .two_stop(two_stop),
        .txd(txd), .tx_ready(tx_ready), .tx_idle(tx_idle)
    );

    // ---------------- reference model ----------------
    int         m_en = 0;
    logic [7:0] m_q[$];
    int         m_st = 0;      // 0 idle, 1 framing, 2 break, 3 guard
    bit         m_bits[$];
    int         m_sub = 0;

    task automatic m_load();
        logic [7:0] d;
        int nd, ones;
        d = m_q.pop_front();
        nd = 5 + int'(char_len);
        ones = 0;
        m_bits.delete();
        m_bits.push_back(1'b0);
        for (int i = 0; i < nd; i++) begin
            m_bits.push_back(d[i]);
            if (d[i]) ones++;
        end
        if (par_mode == 2'd1) m_bits.push_back(ones % 2 == 1);
        if (par_mode == 2'd2) m_bits.push_back(ones % 2 == 0);
        if (par_mode == 2'd3) m_bits.push_back(par_force_val);
        m_bits.push_back(1'b1);
        if (two_stop) m_bits.push_back(1'b1);
        m_st = 1;
        m_sub = 0;
    endtask

    always @(posedge clk) begin : model
        int old_n, blen;
        bit acc, ce;
        if (rst || cmd_reset) begin
            m_en = 0; m_q.delete(); m_bits.delete(); m_st = 0; m_sub = 0;
        end else begin
            old_n = m_q.size();
            acc   = wr_en && (m_en != 0) && (old_n < DEPTH);
            ce    = ext_1x_sel ? ext_tick : tick16;
            blen  = ext_1x_sel ? 1 : 16;
            if (cmd_brk_on) begin
                m_st = 2; m_bits.delete(); m_sub = 0;
            end else begin
                case (m_st)
                    0: if (ce && old_n > 0) m_load();
                    1: if (ce) begin
                        m_sub++;
                        if (m_sub == blen) begin
                            m_sub = 0;
                            void'(m_bits.pop_front());
                            if (m_bits.size() == 0) begin
                                if (old_n > 0) m_load(); else m_st = 0;
                            end
                        end
                    end
                    2: if (cmd_brk_off) begin m_st = 3; m_sub = 0; end
                    default: if (ce) begin
                        m_sub++;
                        if (m_sub == blen) begin m_sub = 0; m_st = 0; end
                    end
                endcase
            end
            if (acc) m_q.push_back(wr_data);
            if (cmd_disable) m_en = 0;
            else if (cmd_enable) m_en = 1;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin : compare
        bit e_txd, e_rdy, e_idl;
        if (cmp_on) begin
            e_txd = (m_st == 1) ? m_bits[0] : (m_st != 2);
            e_rdy = (m_en != 0) && (m_q.size() < DEPTH);
            e_idl = (m_en != 0) && (m_q.size() == 0) && (m_st == 0);
            chk(txd == e_txd, "R9 txd vs model", int'(txd), int'(e_txd));
            chk(tx_ready == e_rdy, "R1 tx_ready vs model", int'(tx_ready), int'(e_rdy));
            chk(tx_idle == e_idl, "R2 tx_idle vs model", int'(tx_idle), int'(e_idl));
        end
    end

    always @(negedge clk) begin
        tcnt++;
        tick16   = tick_run && (tcnt % 2 == 0);
        ext_tick = tick_run && (tcnt % ext_div == 0);
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            bad++; total++;
            $display("FAIL R11 watchdog expired actual=%0d expected=%0d", cycles, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // mask bits: 4 reset, 3 disable, 2 enable, 1 brk_on, 0 brk_off
    task automatic cmd(input logic [4:0] m);
        cmd_reset = m[4]; cmd_disable = m[3]; cmd_enable = m[2];
        cmd_brk_on = m[1]; cmd_brk_off = m[0];
        step(1);
        cmd_reset = 0; cmd_disable = 0; cmd_enable = 0; cmd_brk_on = 0; cmd_brk_off = 0;
    endtask

    task automatic put(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (!tx_idle && n < 30000) begin step(1); n++; end
        chk(tx_idle == 1'b1, req, int'(tx_idle), 1);
    endtask

    task automatic set_cfg(input logic [1:0] l, input logic [1:0] p, input logic pv, input logic ts);
        char_len = l; par_mode = p; par_force_val = pv; two_stop = ts;
    endtask

    initial begin
        step(3);
        cmp_on = 1'b1;
        rst = 1'b0;
        chk(txd == 1'b1 && !tx_ready && !tx_idle, "R6 state after reset", {txd, tx_ready, tx_idle}, 3'b100);

        // R4: write while disabled is dropped
        put(8'hA5);
        step(2);
        cmd(5'b00100);
        chk(tx_ready && tx_idle, "R3 flags after enable (R4 dropped write)", {tx_ready, tx_idle}, 2'b11);

        // R9/R10/R11: 8 data bits, even parity, latency
        set_cfg(2'd3, 2'd1, 1'b0, 1'b0);
        put(8'h3C);
        chk(!tx_idle, "R3 write clears idle", int'(tx_idle), 0);
        begin
            int n = 0;
            while (txd && n < 10) begin step(1); n++; end
            chk(n >= 1 && n <= 2, "R11 start latency in 16x mode", n, 2);
        end
        put(8'h81); put(8'hF0);
        wait_idle("R12 back-to-back burst drained");
        chk(tx_ready, "R2 idle implies ready", int'(tx_ready), 1);

        set_cfg(2'd0, 2'd2, 1'b0, 1'b1);
        put(8'h15); put(8'hEA);
        wait_idle("R10 odd parity 5-bit two stops");
        set_cfg(2'd1, 2'd3, 1'b1, 1'b0);
        put(8'h2D);
        wait_idle("R10 forced parity 6-bit");
        set_cfg(2'd2, 2'd0, 1'b0, 1'b1);
        put(8'h55);
        wait_idle("R9 7-bit no parity");

        // R1: fill queue, overflow write dropped, then drain in 1x mode
        set_cfg(2'd3, 2'd0, 1'b0, 1'b0);
        ext_1x_sel = 1'b1; ext_div = 1; tick_run = 1'b0;
        for (int i = 0; i < DEPTH; i++) put(8'(i * 7 + 1));
        chk(!tx_ready, "R1 ready low when full", int'(tx_ready), 0);
        put(8'hEE);
        tick_run = 1'b1;
        wait_idle("R4 full queue drained without overflow byte");
        ext_div = 3;
        put(8'hC3);
        wait_idle("R11 1x mode frame");
        ext_1x_sel = 1'b0;

        // R6: reset discards queue
        tick_run = 1'b0;
        put(8'h11); put(8'h22); put(8'h33);
        cmd(5'b10000);
        chk(txd && !tx_ready && !tx_idle, "R6 command reset", {txd, tx_ready, tx_idle}, 3'b100);
        cmd(5'b00100);
        chk(tx_idle, "R6 queue discarded", int'(tx_idle), 1);
        tick_run = 1'b1;

        // R6 mid-frame
        put(8'h00);
        step(40);
        cmd(5'b10000);
        chk(txd == 1'b1, "R6 reset mid-frame drives high", int'(txd), 1);

        // R5: graceful disable
        cmd(5'b00100);
        put(8'h96); put(8'h69);
        cmd(5'b01000);
        chk(!tx_ready && !tx_idle, "R5 flags low after disable", {tx_ready, tx_idle}, 0);
        put(8'hFF);
        step(1200);
        chk(txd == 1'b1, "R5 line high after drain", int'(txd), 1);
        cmd(5'b00100);
        chk(tx_idle, "R4 write during disable dropped", int'(tx_idle), 1);

        // R7/R8: break mid-frame, queue retained
        put(8'hFF); put(8'hA0);
        step(50);
        cmd(5'b00010);
        chk(txd == 1'b0, "R7 break takes effect", int'(txd), 0);
        step(100);
        chk(txd == 1'b0, "R7 break held", int'(txd), 0);
        cmd(5'b00011);
        chk(txd == 1'b0, "R13 brk_on wins over brk_off", int'(txd), 0);
        cmd(5'b00001);
        chk(txd == 1'b1, "R8 line high after stop-break", int'(txd), 1);
        step(25);
        chk(txd == 1'b1, "R8 guard time", int'(txd), 1);
        wait_idle("R7 queued byte sent after break");

        // R13: disable wins over enable
        cmd(5'b01100);
        chk(!tx_ready, "R13 disable over enable", int'(tx_ready), 0);
        cmd(5'b10110);
        chk(txd && !tx_ready, "R13 reset over all", {txd, tx_ready}, 2'b10);

        step(5);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule